// File: doc/BRIEF.md
# Character Display Address Counter

This block is the command-decode and address-pointer core of a two-line character display controller. A host presents one byte at a time on an 8-bit bus, together with a register-select line, and pulses a write strobe. With register select low the byte is a command: it can load the pointer for the glyph-pattern memory, load the pointer for the character memory, or set the step direction. With register select high the byte is data. It is stored in whichever memory the last pointer command chose, at the pointer value. The pointer then steps by one.

The two memories are held inside the block. The glyph-pattern memory has 64 rows of 5 bits. The character memory has 128 bytes, of which 80 are visible: two lines of 40. A single pointer serves both memories. In pattern space it is a 6-bit wrapping counter. In character space it jumps across the gaps between the two lines. Combinational refresh read ports let the display scan logic fetch character codes and pattern rows. A flag marks codes that name a user-defined glyph.

Top module: `char_addr_core`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 00H, the target is character memory (`tgt_dd`=1), the direction is increment (`dir_inc`=1), `shift_en` is 0, and both memories read as all zeros.
- R2: A strobed command byte 01AAAAAA with `rs`=0 loads AAAAAA into the pointer and selects glyph-pattern memory (`tgt_dd`=0) in the same clock edge.
- R3: A strobed command byte 1AAAAAAA with `rs`=0, where AAAAAAA is in 00H–27H or 40H–67H, loads AAAAAAA into the pointer and selects character memory (`tgt_dd`=1).
- R4: A character-memory pointer load that falls in a gap is clamped. Values 28H–3FH load 40H, and values 68H–7FH load 00H.
- R5: A strobed byte with `rs`=1 is stored at the current pointer, only in the selected memory, and the pointer then moves by exactly one in the same edge.
- R6: A data byte stored in glyph-pattern memory keeps only bits 4..0. Bits 7..5 are dropped, and `scan_cg_row` shows the 5 kept bits.
- R7: In glyph-pattern space the pointer wraps. Incrementing from 3FH gives 00H, and decrementing from 00H gives 3FH.
- R8: Incrementing in character space steps 27H to 40H and 67H to 00H. Every other address steps up by one.
- R9: Decrementing in character space steps 00H to 67H and 40H to 27H. Every other address steps down by one.
- R10: A strobed command 000001xy with `rs`=0 sets `dir_inc` to x (1 = increment) and `shift_en` to y.
- R11: Other command codes, and bus activity with `wr_stb` low, change neither the pointer, the target, the mode bits nor either memory.
- R12: `scan_user_glyph` is 1 exactly when `scan_dd_code` is below 10H, which is a user-defined glyph code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rs | input | 1 | 0 = command byte, 1 = data byte |
| din | input | 8 | Host byte |
| addr_q | output | 7 | Current pointer value |
| tgt_dd | output | 1 | 1 = character memory selected, 0 = glyph-pattern memory |
| dir_inc | output | 1 | Step direction, 1 = increment |
| shift_en | output | 1 | Latched shift flag from the mode command |
| scan_dd_addr | input | 7 | Refresh read address into character memory |
| scan_dd_code | output | 8 | Character code at `scan_dd_addr` |
| scan_user_glyph | output | 1 | Code at `scan_dd_addr` names a user glyph |
| scan_cg_addr | input | 6 | Refresh read address into glyph-pattern memory |
| scan_cg_row | output | 5 | Pattern row at `scan_cg_addr` |

## Verification
Every strobed byte takes effect on the single rising edge at which `wr_stb` is high. The new pointer, target and mode bits are visible right after that edge. The stored byte shows on the combinational scan ports in the same cycle. The bench drives each byte on a falling edge, holds it through one rising edge, and samples on the next falling edge, one register stage after the stimulus. The gap-jump and wrap results are checked in that same cycle. The scan flag is checked with no clock edge at all, after a short settle delay.

// File: rtl/char_disp_pkg.sv
// Package: shared types for the character display address core.
// Assumes: one target-select bit distinguishes the two memories.
package char_disp_pkg;
    typedef enum logic {
        TGT_CG = 1'b0,
        TGT_DD = 1'b1
    } tgt_e;
endpackage

// File: rtl/cmd_decode.sv
// Module: cmd_decode
// Splits one strobed host byte into exactly one action: load glyph
// pointer, load character pointer, set mode, or store data.
// Assumes: inputs are stable around the clock edge; unused codes give no action.
module cmd_decode (
    input  logic       wr_stb,
    input  logic       rs,
    input  logic [7:0] din,
    output logic       ld_cg,
    output logic       ld_dd,
    output logic       ld_mode,
    output logic       wr_data
);
    // Classify the byte by its leading bits, highest-order match first.
    always_comb begin
        ld_cg   = 1'b0;
        ld_dd   = 1'b0;
        ld_mode = 1'b0;
        wr_data = 1'b0;
        if (wr_stb) begin
            if (rs)                         wr_data = 1'b1;
            else if (din[7])                ld_dd   = 1'b1;
            else if (din[6])                ld_cg   = 1'b1;
            else if (din[5:2] == 4'b0001)   ld_mode = 1'b1;
        end
    end
endmodule

// File: rtl/addr_counter.sv
// Module: addr_counter
// Holds the shared pointer, target select and mode bits. Applies loads
// (with gap clamping for character space) and steps after data stores.
// Assumes: at most one of the load/store strobes is high per cycle.
module addr_counter
    import char_disp_pkg::*;
#(
    parameter int AW       = 7,
    parameter int CG_AW    = 6,
    parameter int LINE_LEN = 40,
    parameter int L2_BASE  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_cg,
    input  logic          ld_dd,
    input  logic          ld_mode,
    input  logic          wr_data,
    input  logic [AW-1:0] val,
    output logic [AW-1:0] addr_q,
    output tgt_e          tgt_q,
    output logic          dir_q,
    output logic          shift_q
);
    localparam logic [AW-1:0] L1_FIRST = '0;
    localparam logic [AW-1:0] L1_LAST  = AW'(LINE_LEN - 1);
    localparam logic [AW-1:0] L2_FIRST = AW'(L2_BASE);
    localparam logic [AW-1:0] L2_LAST  = AW'(L2_BASE + LINE_LEN - 1);
    localparam logic [CG_AW-1:0] CG_ONE = CG_AW'(1);

    logic [AW-1:0]    dd_load;
    logic [AW-1:0]    dd_next;
    logic [CG_AW-1:0] cg_next;
    logic [AW-1:0]    step_next;

    // Clamp a character-space load that lands in a gap to the next line start.
    always_comb begin
        if (val <= L1_LAST)       dd_load = val;
        else if (val < L2_FIRST)  dd_load = L2_FIRST;
        else if (val <= L2_LAST)  dd_load = val;
        else                      dd_load = L1_FIRST;
    end

    // Next character-space address, jumping across the gaps between lines.
    always_comb begin
        if (dir_q) begin
            if (addr_q == L1_LAST)       dd_next = L2_FIRST;
            else if (addr_q == L2_LAST)  dd_next = L1_FIRST;
            else                         dd_next = addr_q + AW'(1);
        end else begin
            if (addr_q == L1_FIRST)      dd_next = L2_LAST;
            else if (addr_q == L2_FIRST) dd_next = L1_LAST;
            else                         dd_next = addr_q - AW'(1);
        end
    end

    // Next glyph-space address: plain modulo step on the narrow field.
    always_comb begin
        cg_next   = dir_q ? addr_q[CG_AW-1:0] + CG_ONE : addr_q[CG_AW-1:0] - CG_ONE;
        step_next = (tgt_q == TGT_DD) ? dd_next : AW'(cg_next);
    end

    // Pointer, target and mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            tgt_q   <= TGT_DD;
            dir_q   <= 1'b1;
            shift_q <= 1'b0;
        end else if (ld_cg) begin
            addr_q  <= AW'(val[CG_AW-1:0]);
            tgt_q   <= TGT_CG;
        end else if (ld_dd) begin
            addr_q  <= dd_load;
            tgt_q   <= TGT_DD;
        end else if (ld_mode) begin
            dir_q   <= val[1];
            shift_q <= val[0];
        end else if (wr_data) begin
            addr_q  <= step_next;
        end
    end

    // R8 / R9: in character space the pointer never sits in a gap.
    a_r8_dd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q == TGT_DD) |-> (addr_q <= L1_LAST || (addr_q >= L2_FIRST && addr_q <= L2_LAST)));

    // R7: in glyph space the bits above the narrow field stay clear.
    a_r7_cg_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_q == TGT_CG) |-> (addr_q >> CG_AW) == '0);

    // R5 / R7: a glyph-space store moves the pointer by exactly one, modulo 64.
    a_r5_cg_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tgt_q == TGT_CG) |=>
        (addr_q[CG_AW-1:0] == ($past(dir_q) ? $past(addr_q[CG_AW-1:0]) + CG_ONE
                                            : $past(addr_q[CG_AW-1:0]) - CG_ONE)));

    // R11: with no strobe nothing in the pointer state moves.
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_cg || ld_dd || ld_mode || wr_data) |=>
        ($stable(addr_q) && $stable(tgt_q) && $stable(dir_q) && $stable(shift_q)));

    // R10: a mode command latches both bits.
    a_r10_mode_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ld_mode |=> (dir_q == $past(val[1]) && shift_q == $past(val[0])));
endmodule

// File: rtl/char_ram.sv
// Module: char_ram
// Single write port, combinational read port storage array, cleared on reset.
// Assumes: depth is a power of two set by the address width.
module char_ram #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise store on write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Refresh read path.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/char_addr_core.sv
// Module: char_addr_core
// Top of the command-decode and pointer core: decodes host bytes, steers
// stores into the glyph-pattern or character memory, exposes refresh reads.
// Assumes: one byte per strobe cycle; the strobe is synchronous to clk.
module char_addr_core
    import char_disp_pkg::*;
#(
    parameter int AW       = 7,
    parameter int CG_AW    = 6,
    parameter int CG_DW    = 5,
    parameter int DW       = 8,
    parameter int LINE_LEN = 40,
    parameter int L2_BASE  = 64,
    parameter int USER_CODES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             rs,
    input  logic [DW-1:0]    din,
    output logic [AW-1:0]    addr_q,
    output logic             tgt_dd,
    output logic             dir_inc,
    output logic             shift_en,
    input  logic [AW-1:0]    scan_dd_addr,
    output logic [DW-1:0]    scan_dd_code,
    output logic             scan_user_glyph,
    input  logic [CG_AW-1:0] scan_cg_addr,
    output logic [CG_DW-1:0] scan_cg_row
);
    logic ld_cg, ld_dd, ld_mode, wr_data;
    logic cg_we, dd_we;
    tgt_e tgt_q;

    cmd_decode u_dec (
        .wr_stb  (wr_stb),
        .rs      (rs),
        .din     (din),
        .ld_cg   (ld_cg),
        .ld_dd   (ld_dd),
        .ld_mode (ld_mode),
        .wr_data (wr_data)
    );

    addr_counter #(
        .AW(AW), .CG_AW(CG_AW), .LINE_LEN(LINE_LEN), .L2_BASE(L2_BASE)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_cg   (ld_cg),
        .ld_dd   (ld_dd),
        .ld_mode (ld_mode),
        .wr_data (wr_data),
        .val     (din[AW-1:0]),
        .addr_q  (addr_q),
        .tgt_q   (tgt_q),
        .dir_q   (dir_inc),
        .shift_q (shift_en)
    );

    // Steer a data store to the memory chosen by the last pointer command.
    always_comb begin
        cg_we  = wr_data && (tgt_q == TGT_CG);
        dd_we  = wr_data && (tgt_q == TGT_DD);
        tgt_dd = (tgt_q == TGT_DD);
    end

    char_ram #(.AW(CG_AW), .DW(CG_DW)) u_cg_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cg_we),
        .waddr (addr_q[CG_AW-1:0]),
        .wdata (din[CG_DW-1:0]),
        .raddr (scan_cg_addr),
        .rdata (scan_cg_row)
    );

    char_ram #(.AW(AW), .DW(DW)) u_dd_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dd_we),
        .waddr (addr_q),
        .wdata (din),
        .raddr (scan_dd_addr),
        .rdata (scan_dd_code)
    );

    // Flag codes that select a user-defined glyph rather than a fixed one.
    always_comb scan_user_glyph = (scan_dd_code < DW'(USER_CODES));

    // R5: a store never reaches both memories.
    a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cg_we, dd_we}));

    // R2 / R3: a pointer command sets the target it names.
    a_r3_dd_select: assert property (@(posedge clk) disable iff (!rst_n)
        ld_dd |=> tgt_dd);
    a_r2_cg_select: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cg |=> !tgt_dd);
endmodule

// File: tb/tb_char_addr_core.sv
module tb_char_addr_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic       rs = 1'b0;
    logic [7:0] din = '0;
    logic [6:0] addr_q;
    logic       tgt_dd, dir_inc, shift_en;
    logic [6:0] scan_dd_addr = '0;
    logic [7:0] scan_dd_code;
    logic       scan_user_glyph;
    logic [5:0] scan_cg_addr = '0;
    logic [4:0] scan_cg_row;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    char_addr_core dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rs(rs), .din(din),
        .addr_q(addr_q), .tgt_dd(tgt_dd), .dir_inc(dir_inc), .shift_en(shift_en),
        .scan_dd_addr(scan_dd_addr), .scan_dd_code(scan_dd_code),
        .scan_user_glyph(scan_user_glyph),
        .scan_cg_addr(scan_cg_addr), .scan_cg_row(scan_cg_row)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One strobed byte, driven on a falling edge; returns one falling edge later.
    task automatic put(input logic r, input logic [7:0] b);
        @(negedge clk);
        wr_stb = 1'b1; rs = r; din = b;
        @(negedge clk);
        wr_stb = 1'b0; rs = 1'b0; din = '0;
    endtask

    task automatic dd_at(input logic [6:0] a, output int v);
        scan_dd_addr = a; #1; v = scan_dd_code;
    endtask

    task automatic cg_at(input logic [5:0] a, output int v);
        scan_cg_addr = a; #1; v = scan_cg_row;
    endtask

    task automatic t_reset;
        int v;
        check("R1 addr", addr_q, 0);
        check("R1 tgt", tgt_dd, 1);
        check("R1 dir", dir_inc, 1);
        check("R1 shift", shift_en, 0);
        dd_at(7'h05, v); check("R1 dd clear", v, 0);
        cg_at(6'h05, v); check("R1 cg clear", v, 0);
    endtask

    task automatic t_cg_load_store;
        int v;
        put(1'b0, 8'h55);
        check("R2 addr", addr_q, 8'h15);
        check("R2 tgt", tgt_dd, 0);
        put(1'b1, 8'hFF);
        cg_at(6'h15, v); check("R6 mask", v, 5'h1F);
        check("R5 step", addr_q, 8'h16);
        dd_at(7'h15, v); check("R5 other mem untouched", v, 0);
        put(1'b1, 8'hE4);
        cg_at(6'h16, v); check("R6 mask2", v, 5'h04);
    endtask

    task automatic t_cg_wrap;
        int v;
        put(1'b0, 8'h7F);
        put(1'b1, 8'hAA);
        cg_at(6'h3F, v); check("R6 top row", v, 5'h0A);
        check("R7 wrap up", addr_q, 0);
        put(1'b0, 8'h04);
        check("R10 dir dec", dir_inc, 0);
        check("R10 shift0", shift_en, 0);
        put(1'b1, 8'h03);
        cg_at(6'h00, v); check("R5 row0", v, 3);
        check("R7 wrap down", addr_q, 8'h3F);
    endtask

    task automatic t_dd_inc;
        int v;
        put(1'b0, 8'h07);
        check("R10 dir inc", dir_inc, 1);
        check("R10 shift1", shift_en, 1);
        put(1'b0, 8'hA7);
        check("R3 addr", addr_q, 8'h27);
        check("R3 tgt", tgt_dd, 1);
        put(1'b1, 8'h41);
        dd_at(7'h27, v); check("R5 dd store", v, 8'h41);
        check("R8 27->40", addr_q, 8'h40);
        put(1'b0, 8'hE7);
        put(1'b1, 8'h42);
        check("R8 67->00", addr_q, 0);
        put(1'b1, 8'h43);
        check("R8 plain", addr_q, 1);
    endtask

    task automatic t_dd_dec;
        int v;
        put(1'b0, 8'h06);
        put(1'b0, 8'h04);
        put(1'b0, 8'h80);
        put(1'b1, 8'h50);
        dd_at(7'h00, v); check("R5 dd store0", v, 8'h50);
        check("R9 00->67", addr_q, 8'h67);
        put(1'b0, 8'hC0);
        put(1'b1, 8'h51);
        check("R9 40->27", addr_q, 8'h27);
        put(1'b0, 8'h85);
        put(1'b1, 8'h52);
        check("R9 plain", addr_q, 8'h04);
        put(1'b0, 8'h06);
    endtask

    task automatic t_clamp;
        put(1'b0, 8'hA8); check("R4 28->40", addr_q, 8'h40);
        put(1'b0, 8'hBF); check("R4 3F->40", addr_q, 8'h40);
        put(1'b0, 8'hE8); check("R4 68->00", addr_q, 0);
        put(1'b0, 8'hFF); check("R4 7F->00", addr_q, 0);
    endtask

    task automatic t_ignore;
        int v;
        put(1'b0, 8'h8A);
        put(1'b0, 8'h01);
        put(1'b0, 8'h20);
        put(1'b0, 8'h3C);
        check("R11 addr held", addr_q, 8'h0A);
        check("R11 tgt held", tgt_dd, 1);
        check("R11 dir held", dir_inc, 1);
        @(negedge clk);
        rs = 1'b1; din = 8'h77;
        @(negedge clk);
        @(negedge clk);
        rs = 1'b0; din = '0;
        dd_at(7'h0A, v); check("R11 no strobe no store", v, 0);
        check("R11 no strobe no step", addr_q, 8'h0A);
    endtask

    task automatic t_glyph_flag;
        put(1'b0, 8'h90);
        put(1'b1, 8'h0F);
        put(1'b1, 8'h10);
        scan_dd_addr = 7'h10; #1;
        check("R12 code 0F user", scan_user_glyph, 1);
        scan_dd_addr = 7'h11; #1;
        check("R12 code 10 fixed", scan_user_glyph, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cg_load_store();
        t_cg_wrap();
        t_dd_inc();
        t_dd_dec();
        t_clamp();
        t_ignore();
        t_glyph_flag();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule